// File: doc/BRIEF.md
# Table-Driven Packet Header Classifier

This block decides where a packet goes by running a short program held in table memory. The program is a series of 32-bit instruction words. Header bytes arrive one at a time on a valid/ready byte stream and are shifted into a 128-bit window. Compare, merge and mask instructions build up a 128-bit mismatch accumulator from slices of that window. A zero accumulator means the header matched. Conditional jumps move through the table on that zero flag. A route instruction, or a failure, ends the decision and yields one result: a route target, or a discard with an error flag.

Instruction words are fetched one at a time through a request/response port. The request is valid/ready: the address holds steady until it is accepted. The response is valid/ready: `fetch_rsp_ready` is high only while the engine waits for a word. Back-pressure on the packet input comes from the engine. `in_ready` is high only while a STEP is pulling header bytes, or while the tail of a decided packet is being flushed, so no byte is ever lost. The result port is valid/ready. Once raised, the result holds until it is accepted. After acceptance, the rest of the packet, up to the byte flagged last, is consumed and dropped, and the engine returns to idle to wait for the next packet.

Top module: `hdr_classifier`

## Requirements
- R1: Encoding. If bit 31 is set, the word is a jump: bit 30 chooses jump-on-nonzero (1) or jump-on-zero (0), and bits [29:0] give the target word address. Otherwise bits [31:28] hold the opcode (1 compare, 2 merge, 3 mask, 4 step, 5 route-on-zero, 6 route-on-nonzero, 7 route-always), bits [27:24] hold a byte shift s, and bits [23:0] hold the immediate.
- R2: When a packet begins (`in_valid` seen while idle), the accumulator and window are cleared and the first fetch is issued at `TBL_BASE`. No state carries over from the previous packet.
- R3: Compare replaces the accumulator with (window XOR immediate<<8s), kept only in bits [8s+23:8s]; all other bits become zero.
- R4: Merge ORs the same 24-bit mismatch, at its own shift, into the accumulator. A 48-bit address therefore matches as compare, merge, then route-on-zero.
- R5: Mask ANDs the accumulator with immediate<<8s, which clears every bit outside the immediate's set bits.
- R6: STEP n shifts n bytes into the window. Each new byte enters bits [7:0] and older bytes move up 8 bits. The engine stalls with `in_ready` high until each byte arrives. Once the byte flagged last has been taken, the remaining steps shift in zeros without consuming input.
- R7: A jump loads its target when its condition holds (zero accumulator for jump-on-zero, nonzero for jump-on-nonzero). Otherwise execution continues at the next word.
- R8: Route-on-zero, route-on-nonzero and route-always end the packet with target = immediate[TGT_W-1:0] and discard low when their condition holds. A route whose condition fails falls through to the next word.
- R9: Opcode 0, or a compare, merge or mask with s above 13, ends the packet with discard and error both high.
- R10: A STEP that needs a header byte beyond `HDR_MAX` bytes ends the packet with discard and error both high. A packet that uses exactly `HDR_MAX` bytes is still routed normally.
- R11: `res_valid` with target, discard and error holds steady until `res_ready`. While it is high, no byte is taken and no fetch is requested. After acceptance, the packet's remaining bytes through the last one are consumed.
- R12: A fetch request keeps `fetch_addr` steady until `fetch_req_ready`. `in_ready` and `fetch_req_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header byte valid |
| in_ready | output | 1 | Engine takes the byte this cycle |
| in_data | input | 8 | Header byte |
| in_last | input | 1 | Final byte of the packet |
| fetch_req_valid | output | 1 | Instruction fetch request |
| fetch_req_ready | input | 1 | Table memory accepts the request |
| fetch_addr | output | 30 | Word address of the requested instruction |
| fetch_rsp_valid | input | 1 | Instruction word returned |
| fetch_rsp_ready | output | 1 | Engine is waiting for the word |
| fetch_rsp_data | input | 32 | Instruction word |
| res_valid | output | 1 | Decision available |
| res_ready | input | 1 | Decision accepted |
| res_target | output | TGT_W | Route target |
| res_discard | output | 1 | Packet is discarded |
| res_error | output | 1 | Decision ended on a fault |

## Verification
The main function is run with an address that matches across a compare and a merge, and with the same address differing only in its last byte. Together these show that the merge really adds its mismatch rather than replacing the accumulator. A type-field packet with a nonzero neighbouring byte is classified with and without the mask, which shows that the mask clears the unwanted lane. The same table is then run with jump-on-zero and with jump-on-nonzero, and with two packet types, to separate a taken jump from a fall-through. Boundary patterns cover a packet shorter than its STEP (zero fill), a STEP that ends exactly at the header limit against one that crosses it, illegal words, a fresh table that routes on an accumulator left dirty by the previous packet, and a stalling fetch port with a slow result consumer.

// File: rtl/hdrc_pkg.sv
package hdrc_pkg;
  localparam int WIN_W     = 128;
  localparam int WIN_BYTES = WIN_W / 8;
  localparam int MAX_SHIFT = WIN_BYTES - 3;

  typedef enum logic [3:0] {
    OP_ILL  = 4'd0,
    OP_CMP  = 4'd1,
    OP_OR   = 4'd2,
    OP_MASK = 4'd3,
    OP_STEP = 4'd4,
    OP_RZ   = 4'd5,
    OP_RNZ  = 4'd6,
    OP_RA   = 4'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_STEP, S_RESULT, S_DRAIN
  } state_e;
endpackage

// File: rtl/hdrc_window.sv
module hdrc_window #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic [7:0]   byte_in,
  output logic [W-1:0] win
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) win <= '0;
    else if (shift_en) win <= {win[W-9:0], byte_in};
  end
endmodule

// File: rtl/hdrc_match.sv
module hdrc_match
  import hdrc_pkg::*;
#(
  parameter int W = 128
) (
  input  logic [W-1:0] win,
  input  logic [W-1:0] acc,
  input  op_e          op,
  input  logic [3:0]   shift,
  input  logic [23:0]  imm,
  output logic [W-1:0] acc_next,
  output logic         shift_ok
);
  logic [6:0]   amt;
  logic [W-1:0] field;
  logic [W-1:0] lane;
  logic [W-1:0] miss;

  assign amt      = {shift, 3'b000};
  assign field    = {{(W-24){1'b0}}, imm} << amt;
  assign lane     = {{(W-24){1'b0}}, 24'hFFFFFF} << amt;
  assign miss     = (win ^ field) & lane;
  assign shift_ok = (int'(shift) <= MAX_SHIFT);

  always_comb begin
    case (op)
      OP_CMP:  acc_next = miss;
      OP_OR:   acc_next = acc | miss;
      OP_MASK: acc_next = acc & field;
      default: acc_next = acc;
    endcase
  end
endmodule

// File: rtl/hdr_classifier.sv
module hdr_classifier
  import hdrc_pkg::*;
#(
  parameter int          TGT_W    = 8,
  parameter int          HDR_MAX  = 64,
  parameter logic [29:0] TBL_BASE = 30'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             fetch_req_valid,
  input  logic             fetch_req_ready,
  output logic [29:0]      fetch_addr,
  input  logic             fetch_rsp_valid,
  output logic             fetch_rsp_ready,
  input  logic [31:0]      fetch_rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [TGT_W-1:0] res_target,
  output logic             res_discard,
  output logic             res_error
);
  localparam int CW = $clog2(HDR_MAX + 1);

  state_e       state;
  logic [29:0]  pc;
  logic [WIN_W-1:0] acc, acc_next, win;
  logic [7:0]   step_left;
  logic [CW-1:0] hdr_cnt;
  logic         seen_last;

  // instruction fields
  logic        is_jmp, jmp_nz, acc_nz, shift_ok, take;
  op_e         op;
  logic [3:0]  sh;
  logic [23:0] imm;

  assign is_jmp = fetch_rsp_data[31];
  assign jmp_nz = fetch_rsp_data[30];
  assign op     = op_e'(fetch_rsp_data[31:28]);
  assign sh     = fetch_rsp_data[27:24];
  assign imm    = fetch_rsp_data[23:0];
  assign acc_nz = |acc;
  assign take   = jmp_nz ? acc_nz : !acc_nz;

  logic exec, stepping, full, win_clr, win_shift;
  assign exec     = (state == S_WAIT) && fetch_rsp_valid;
  assign stepping = (state == S_STEP) && (step_left != 8'd0);
  assign full     = (hdr_cnt == CW'(HDR_MAX));
  assign win_clr  = (state == S_IDLE) && in_valid;
  assign win_shift = stepping && (seen_last || (!full && in_valid));

  assign in_ready = (stepping && !seen_last && !full) || (state == S_DRAIN);
  assign fetch_req_valid = (state == S_FETCH);
  assign fetch_addr      = pc;
  assign fetch_rsp_ready = (state == S_WAIT);
  assign res_valid       = (state == S_RESULT);

  hdrc_window #(.W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .shift_en(win_shift),
    .byte_in(seen_last ? 8'h00 : in_data), .win(win)
  );

  hdrc_match #(.W(WIN_W)) u_match (
    .win(win), .acc(acc), .op(op), .shift(sh), .imm(imm),
    .acc_next(acc_next), .shift_ok(shift_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      pc          <= TBL_BASE;
      acc         <= '0;
      step_left   <= '0;
      hdr_cnt     <= '0;
      seen_last   <= 1'b0;
      res_target  <= '0;
      res_discard <= 1'b0;
      res_error   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          pc        <= TBL_BASE;
          acc       <= '0;
          hdr_cnt   <= '0;
          seen_last <= 1'b0;
          state     <= S_FETCH;
        end
        S_FETCH: if (fetch_req_ready) state <= S_WAIT;
        S_WAIT: if (exec) begin
          if (is_jmp) begin
            pc    <= take ? fetch_rsp_data[29:0] : pc + 30'd1;
            state <= S_FETCH;
          end else begin
            case (op)
              OP_CMP, OP_OR, OP_MASK: begin
                if (shift_ok) begin
                  acc   <= acc_next;
                  pc    <= pc + 30'd1;
                  state <= S_FETCH;
                end else begin
                  res_discard <= 1'b1;
                  res_error   <= 1'b1;
                  state       <= S_RESULT;
                end
              end
              OP_STEP: begin
                step_left <= imm[7:0];
                pc        <= pc + 30'd1;
                state     <= S_STEP;
              end
              OP_RZ, OP_RNZ, OP_RA: begin
                if (op == OP_RA || (op == OP_RZ) == !acc_nz) begin
                  res_target  <= imm[TGT_W-1:0];
                  res_discard <= 1'b0;
                  res_error   <= 1'b0;
                  state       <= S_RESULT;
                end else begin
                  pc    <= pc + 30'd1;
                  state <= S_FETCH;
                end
              end
              default: begin
                res_discard <= 1'b1;
                res_error   <= 1'b1;
                state       <= S_RESULT;
              end
            endcase
          end
        end
        S_STEP: begin
          if (step_left == 8'd0) begin
            state <= S_FETCH;
          end else if (seen_last) begin
            step_left <= step_left - 8'd1;
          end else if (full) begin
            res_discard <= 1'b1;
            res_error   <= 1'b1;
            state       <= S_RESULT;
          end else if (in_valid) begin
            step_left <= step_left - 8'd1;
            hdr_cnt   <= hdr_cnt + CW'(1);
            seen_last <= in_last;
          end
        end
        S_RESULT: if (res_ready) state <= seen_last ? S_IDLE : S_DRAIN;
        S_DRAIN: if (in_valid && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdr_classifier_chk.sv
module hdr_classifier_chk #(
  parameter int TGT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             fetch_req_valid,
  input logic             fetch_req_ready,
  input logic [29:0]      fetch_addr,
  input logic             res_valid,
  input logic             res_ready,
  input logic [TGT_W-1:0] res_target,
  input logic             res_discard,
  input logic             res_error
);
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_target)
      && $stable(res_discard) && $stable(res_error));

  assert_no_input_on_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready && !fetch_req_valid);

  assert_fetch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid && !fetch_req_ready |=> fetch_req_valid && $stable(fetch_addr));

  assert_fetch_input_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req_valid && in_ready));

  assert_error_discards_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_error |-> res_discard);
endmodule

bind hdr_classifier hdr_classifier_chk #(.TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
  .fetch_addr(fetch_addr), .res_valid(res_valid), .res_ready(res_ready),
  .res_target(res_target), .res_discard(res_discard), .res_error(res_error)
);

// File: tb/hdr_classifier_bench.sv
module hdr_classifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        fetch_req_valid, fetch_rsp_ready;
  logic        mem_rdy = 1'b1, mem_toggle = 1'b0;
  logic [29:0] fetch_addr;
  logic        pend = 1'b0;
  logic [5:0]  paddr = '0;
  logic        res_valid, res_ready = 1'b0, res_discard, res_error;
  logic [7:0]  res_target;
  logic [31:0] mem [0:63];

  int checks = 0, errors = 0, excl_bad = 0;
  logic [7:0] pkt [0:63];
  int pkt_len;

  hdr_classifier #(.TGT_W(8), .HDR_MAX(16), .TBL_BASE(30'd8)) u_hdr_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .fetch_req_valid(fetch_req_valid),
    .fetch_req_ready(mem_rdy), .fetch_addr(fetch_addr), .fetch_rsp_valid(pend),
    .fetch_rsp_ready(fetch_rsp_ready), .fetch_rsp_data(mem[paddr]),
    .res_valid(res_valid), .res_ready(res_ready), .res_target(res_target),
    .res_discard(res_discard), .res_error(res_error)
  );

  always @(posedge clk) begin
    pend  <= fetch_req_valid && mem_rdy;
    paddr <= fetch_addr[5:0];
  end
  always @(negedge clk) mem_rdy <= mem_toggle ? ~mem_rdy : 1'b1;
  always @(negedge clk) if (rst_n && in_ready && fetch_req_valid) excl_bad++;

  function automatic logic [31:0] ins(logic [3:0] op, logic [3:0] sh, logic [23:0] imm);
    return {op, sh, imm};
  endfunction
  function automatic logic [31:0] jmp(logic nz, int t);
    return {1'b1, nz, 30'(t)};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic run_case(string tag, int exp_tgt, bit exp_disc, int hold);
    logic [29:0] first_addr;
    logic [7:0]  tgt;
    logic        disc, err;
    bit          stable_ok;
    fork
      begin
        for (int i = 0; i < pkt_len; i++) begin
          @(negedge clk);
          in_valid = 1'b1; in_data = pkt[i]; in_last = (i == pkt_len - 1);
          #1;
          while (!in_ready) begin @(negedge clk); #1; end
          @(posedge clk);
        end
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      end
      begin
        do @(negedge clk); while (!fetch_req_valid);
        first_addr = fetch_addr;
      end
      begin
        do @(negedge clk); while (!res_valid);
        tgt = res_target; disc = res_discard; err = res_error;
        stable_ok = 1'b1;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          if (!res_valid || res_target != tgt || res_discard != disc || res_error != err)
            stable_ok = 1'b0;
        end
        res_ready = 1'b1;
        @(negedge clk); res_ready = 1'b0;
      end
    join
    chk(first_addr == 30'd8, "R2", "first fetch address", int'(first_addr), 8);
    chk(disc == exp_disc && err == exp_disc, tag, "discard/error", {disc, err}, {exp_disc, exp_disc});
    if (!exp_disc) chk(tgt == 8'(exp_tgt), tag, "route target", tgt, exp_tgt);
    if (hold > 0) chk(stable_ok, "R11", "result held under back-pressure", stable_ok, 1);
  endtask

  task automatic set_pkt(int n, int seed);
    pkt_len = n;
    for (int i = 0; i < n; i++) pkt[i] = 8'(seed + i * 7);
  endtask

  task automatic t_reset();
    chk(!res_valid, "R11", "reset res_valid", res_valid, 0);
    chk(!in_ready, "R12", "reset in_ready", in_ready, 0);
    chk(!fetch_req_valid, "R12", "reset fetch_req_valid", fetch_req_valid, 0);
  endtask

  task automatic t_mac();
    clear_prog();
    mem[8] = ins(4, 0, 6); mem[9] = ins(1, 3, 24'h863324);
    mem[10] = ins(2, 0, 24'h17bfdd); mem[11] = ins(5, 0, 8); mem[12] = ins(7, 0, 0);
    set_pkt(9, 1);
    pkt[0] = 8'h86; pkt[1] = 8'h33; pkt[2] = 8'h24;
    pkt[3] = 8'h17; pkt[4] = 8'hbf; pkt[5] = 8'hdd;
    mem_toggle = 1'b1;
    run_case("R4 R6 R8 R12 mac match", 8, 0, 3);
    mem_toggle = 1'b0;
    pkt[5] = 8'hde;
    run_case("R3 R4 R8 mac miss falls through", 0, 0, 0);
    clear_prog(); mem[8] = ins(5, 0, 7); mem[9] = ins(7, 0, 1);
    set_pkt(3, 5);
    run_case("R2 accumulator cleared per packet", 7, 0, 0);
  endtask

  task automatic t_type(bit use_mask, bit nz);
    clear_prog();
    mem[8] = ins(4, 0, 14); mem[9] = ins(1, 0, 24'h000800);
    mem[10] = use_mask ? ins(3, 0, 24'h00ffff) : ins(2, 0, 24'h000800);
    mem[11] = jmp(nz, 13); mem[12] = ins(7, 0, nz ? 5 : 0); mem[13] = ins(7, 0, nz ? 0 : 5);
    set_pkt(16, 3); pkt[11] = 8'hAA; pkt[12] = 8'h08; pkt[13] = 8'h00;
    run_case(use_mask ? "R5 R7 type match" : "R5 no mask keeps lane", use_mask ? 5 : 0, 0, 0);
    if (use_mask) begin
      pkt[12] = 8'h86; pkt[13] = 8'hdd;
      run_case(nz ? "R7 jnz taken" : "R7 jz not taken", 0, 0, 0);
    end
  endtask

  task automatic t_rnz();
    clear_prog();
    mem[8] = ins(4, 0, 2); mem[9] = ins(1, 0, 24'h00abcd);
    mem[10] = ins(6, 0, 3); mem[11] = ins(7, 0, 4);
    set_pkt(4, 9); pkt[0] = 8'hab; pkt[1] = 8'hcd;
    run_case("R8 rnz falls through on match", 4, 0, 0);
    pkt[1] = 8'hce;
    run_case("R8 rnz routes on miss", 3, 0, 0);
  endtask

  task automatic t_illegal();
    clear_prog(); mem[8] = 32'h0;
    set_pkt(5, 2);
    run_case("R9 opcode zero", 0, 1, 2);
    mem[8] = ins(1, 14, 24'h0);
    run_case("R1 R9 shift above 13", 0, 1, 0);
  endtask

  task automatic t_limit();
    clear_prog(); mem[8] = ins(4, 0, 20); mem[9] = ins(7, 0, 1);
    set_pkt(30, 4);
    run_case("R10 overflow", 0, 1, 0);
    mem[8] = ins(4, 0, 16);
    set_pkt(20, 6);
    run_case("R10 exactly at limit", 1, 0, 0);
  endtask

  task automatic t_short();
    clear_prog();
    mem[8] = ins(4, 0, 6); mem[9] = ins(1, 0, 24'h040000);
    mem[10] = ins(5, 0, 2); mem[11] = ins(7, 0, 0);
    set_pkt(4, 0); pkt[3] = 8'h04;
    run_case("R6 zero fill after last byte", 2, 0, 0);
    set_pkt(2, 0);
    clear_prog(); mem[8] = ins(7, 0, 9);
    run_case("R11 next packet after short one", 9, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_prog();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mac();
    t_type(1, 0);
    t_type(1, 1);
    t_type(0, 0);
    t_rnz();
    t_illegal();
    t_limit();
    t_short();
    chk(excl_bad == 0, "R12", "in_ready with fetch request", excl_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule